// File: doc/BRIEF.md
# Two-Level Write-Back Cache Controller

This block sits between a processor and a word-wide main-memory port. It holds two caches. The first is a direct-mapped store with one word per line. The second is a set-associative store with one word per way, and it picks the way to replace by age. A request always probes the first level. The second level is consulted only when the first level misses, and memory is reached only when both miss. A first-level hit completes in a single cycle. Every other case holds `req_ready` low until the controller has finished its sequence.

Both levels are write-back and neither allocates on a write miss. A write that hits a level updates only that copy and marks it dirty. A write that misses a level is passed down to the next level. A read miss fills the first level. If memory supplied the word, it also fills the second level. Any dirty line that a fill displaces is pushed one level down before the fill is made.

The memory port raises `mem_req` and holds the address, direction and write data steady until `mem_ack` pulses for one cycle. The returned word is taken from `mem_rdata` in that same cycle. The latency is whatever the memory chooses.

Top module: `twolvl_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0, `mem_req` is 0 and every line in both levels is invalid, so the first read of any address produces a memory read.
- R2: A request that hits the first level gets `resp_valid` in the cycle right after acceptance, with no memory traffic.
- R3: A request that misses the first level and hits the second completes without any memory access.
- R4: A read that misses both levels issues exactly one memory read of the requested address and returns that word. The word is installed in both levels, so a repeat read is a one-cycle hit.
- R5: A write that hits the first level updates only that copy, makes no memory access, and later reads return the new word.
- R6: A write that misses the first level but hits the second updates the second level without memory traffic and does not allocate in the first level.
- R7: A write that misses both levels produces exactly one memory write (`mem_we`=1) of the address and data, and allocates nowhere, so a later read of that address goes to memory.
- R8: On a read miss, a dirty first-level line at that index is written into the second level when the second level holds its address, with no memory write. Otherwise it is written to memory. This happens before the fill.
- R9: Each second-level set keeps a 2-bit age per way. The accessed way becomes 0 and valid ways younger than it advance by one. A fill uses the lowest invalid way, or else the way of age 3.
- R10: A dirty second-level victim is written to memory before the memory read that replaces it, so its data is kept.
- R11: While a request is being sequenced, `req_ready` is 0. `mem_req` stays high with a stable address and direction until `mem_ack`, and it is low in the cycle after the ack.
- R12: Each accepted request gives exactly one one-cycle `resp_valid`, and only while `req_ready` is 1. `resp_rdata` carries the read word, or the written word for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 32 | Write word |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Read word, or written word for writes |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 32 | Memory write word |
| mem_ack | input | 1 | One-cycle completion from memory |
| mem_rdata | input | 32 | Memory read word, valid with mem_ack |

## Verification
The port properties take for granted that `mem_ack` is a single-cycle pulse that appears only while `mem_req` is high. They also assume the processor offers a request only as a one-cycle strobe that is sampled when `req_ready` is high. The bench's memory model waits 1 to 4 cycles on each access and then acks it exactly once. It checks on every waiting cycle that the request has not moved. The directed traffic works within one set so that it forces age-ordered and dirty evictions. A random phase then mixes reads and writes across four sets, and every returned word is compared against a reference copy of memory.

// File: rtl/twolvl_cache_pkg.sv
`timescale 1ns/1ps
package twolvl_cache_pkg;

  // Sequencer states of the controller
  typedef enum logic [2:0] {
    ST_IDLE,      // accept and probe first level
    ST_VIC_L2,    // push dirty first-level victim into second level
    ST_VIC_MEM,   // victim missed second level: write it to memory
    ST_L2_LOOK,   // probe second level for the request address
    ST_EVICT_MEM, // dirty second-level victim going to memory
    ST_RD_ISSUE,  // raise the memory read after an eviction
    ST_RD_MEM,    // wait for memory read data
    ST_WR_MEM     // write miss passed through to memory
  } seq_state_t;

endpackage

// File: rtl/tlc_l1_store.sv
`timescale 1ns/1ps
module tlc_l1_store #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              hit,
  output logic              vic_dirty,
  output logic [ADDR_W-1:0] vic_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_dirty
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [LINES-1:0]  valid_q;
  logic [LINES-1:0]  dirty_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  logic [IDX_W-1:0] look_idx;
  logic [TAG_W-1:0] look_tag;
  logic [IDX_W-1:0] wr_idx;

  assign look_idx = look_addr[IDX_W-1:0];
  assign look_tag = look_addr[ADDR_W-1:IDX_W];
  assign wr_idx   = wr_addr[IDX_W-1:0];

  assign hit       = valid_q[look_idx] && (tag_q[look_idx] == look_tag);
  assign vic_dirty = valid_q[look_idx] && dirty_q[look_idx];
  assign vic_addr  = {tag_q[look_idx], look_idx};
  assign rd_data   = data_q[look_idx];

  // state bits carry reset
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  // tag and data arrays: plain write port, no reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_addr[ADDR_W-1:IDX_W];
      data_q[wr_idx] <= wr_data;
    end
  end

endmodule

// File: rtl/tlc_l2_age.sv
`timescale 1ns/1ps
module tlc_l2_age #(
  parameter int SETS = 16,
  parameter int WAYS = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [$clog2(SETS)-1:0] look_set,
  input  logic [WAYS-1:0]         look_valid,
  output logic [$clog2(WAYS)-1:0] vic_way,
  input  logic                    touch_en,
  input  logic [$clog2(SETS)-1:0] touch_set,
  input  logic [$clog2(WAYS)-1:0] touch_way,
  input  logic [WAYS-1:0]         touch_valid
);
  localparam int WAY_W = $clog2(WAYS);
  localparam int AGE_W = WAY_W;
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WAYS - 1);

  logic [WAYS-1:0][AGE_W-1:0] age_q [SETS];
  logic [AGE_W-1:0]           ref_age;

  // an invalid way counts as the oldest, so a fill ages every valid way
  assign ref_age = touch_valid[touch_way] ? age_q[touch_set][touch_way] : AGE_MAX;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) age_q[s] <= '0;
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[touch_set][w] <= '0;
        else if (touch_valid[w] && (age_q[touch_set][w] < ref_age))
          age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
      end
    end
  end

  // lowest invalid way wins; otherwise the oldest valid way
  always_comb begin
    vic_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (age_q[look_set][w] == AGE_MAX) vic_way = WAY_W'(w);
    for (int w = WAYS - 1; w >= 0; w--)
      if (!look_valid[w]) vic_way = WAY_W'(w);
  end

endmodule

// File: rtl/tlc_l2_store.sv
`timescale 1ns/1ps
module tlc_l2_store #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SETS   = 16,
  parameter int WAYS   = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       look_addr,
  output logic                    hit,
  output logic [$clog2(WAYS)-1:0] hit_way,
  output logic [DATA_W-1:0]       hit_data,
  output logic [$clog2(WAYS)-1:0] vic_way,
  output logic                    vic_dirty,
  output logic [ADDR_W-1:0]       vic_addr,
  output logic [DATA_W-1:0]       vic_data,
  input  logic                    acc_en,
  input  logic                    acc_wr,
  input  logic [$clog2(WAYS)-1:0] acc_way,
  input  logic [DATA_W-1:0]       acc_data,
  input  logic                    acc_dirty
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - SET_W;
  localparam int ENTRIES = SETS * WAYS;

  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAYS-1:0]   dirty_q [SETS];
  logic [TAG_W-1:0]  tag_q   [ENTRIES];
  logic [DATA_W-1:0] data_q  [ENTRIES];

  logic [SET_W-1:0]  look_set;
  logic [TAG_W-1:0]  look_tag;
  logic [TAG_W-1:0]  way_tag  [WAYS];
  logic [DATA_W-1:0] way_data [WAYS];
  logic [WAYS-1:0]   way_hit;

  assign look_set = look_addr[SET_W-1:0];
  assign look_tag = look_addr[ADDR_W-1:SET_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign way_tag[w]  = tag_q[{look_set, WAY_W'(w)}];
    assign way_data[w] = data_q[{look_set, WAY_W'(w)}];
    assign way_hit[w]  = valid_q[look_set][w] && (way_tag[w] == look_tag);
  end

  assign hit = |way_hit;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (way_hit[w]) hit_way = WAY_W'(w);
  end

  assign hit_data  = way_data[hit_way];
  assign vic_dirty = valid_q[look_set][vic_way] && dirty_q[look_set][vic_way];
  assign vic_addr  = {way_tag[vic_way], look_set};
  assign vic_data  = way_data[vic_way];

  // accesses always target the set of look_addr
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else if (acc_en && acc_wr) begin
      valid_q[look_set][acc_way] <= 1'b1;
      dirty_q[look_set][acc_way] <= acc_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (acc_en && acc_wr) begin
      tag_q[{look_set, acc_way}]  <= look_tag;
      data_q[{look_set, acc_way}] <= acc_data;
    end
  end

  tlc_l2_age #(
    .SETS (SETS),
    .WAYS (WAYS)
  ) u_age (
    .clk         (clk),
    .rst         (rst),
    .look_set    (look_set),
    .look_valid  (valid_q[look_set]),
    .vic_way     (vic_way),
    .touch_en    (acc_en),
    .touch_set   (look_set),
    .touch_way   (acc_way),
    .touch_valid (valid_q[look_set])
  );

endmodule

// File: rtl/twolvl_cache.sv
`timescale 1ns/1ps
module twolvl_cache #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int L1_LINES = 16,
  parameter int L2_SETS  = 16,
  parameter int L2_WAYS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  import twolvl_cache_pkg::*;

  localparam int WAY_W = $clog2(L2_WAYS);

  seq_state_t        state;
  logic              r_we;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata;
  logic [ADDR_W-1:0] v_addr;
  logic [DATA_W-1:0] v_data;
  logic [WAY_W-1:0]  e_way;

  // first level
  logic              l1_hit, l1_vdirty;
  logic [ADDR_W-1:0] l1_vaddr;
  logic [DATA_W-1:0] l1_rdata;
  logic              l1_wr_en, l1_wr_dirty;
  logic [ADDR_W-1:0] l1_wr_addr;
  logic [DATA_W-1:0] l1_wr_data;

  // second level
  logic [ADDR_W-1:0] l2_look_addr;
  logic              l2_hit, l2_vdirty;
  logic [WAY_W-1:0]  l2_hit_way, l2_vic_way;
  logic [DATA_W-1:0] l2_hit_data, l2_vic_data;
  logic [ADDR_W-1:0] l2_vic_addr;
  logic              l2_acc_en, l2_acc_wr, l2_acc_dirty;
  logic [WAY_W-1:0]  l2_acc_way;
  logic [DATA_W-1:0] l2_acc_data;

  assign req_ready = (state == ST_IDLE);

  tlc_l1_store #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LINES  (L1_LINES)
  ) u_l1 (
    .clk       (clk),
    .rst       (rst),
    .look_addr (req_addr),
    .hit       (l1_hit),
    .vic_dirty (l1_vdirty),
    .vic_addr  (l1_vaddr),
    .rd_data   (l1_rdata),
    .wr_en     (l1_wr_en),
    .wr_addr   (l1_wr_addr),
    .wr_data   (l1_wr_data),
    .wr_dirty  (l1_wr_dirty)
  );

  assign l2_look_addr = (state == ST_VIC_L2) ? v_addr : r_addr;

  tlc_l2_store #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SETS   (L2_SETS),
    .WAYS   (L2_WAYS)
  ) u_l2 (
    .clk       (clk),
    .rst       (rst),
    .look_addr (l2_look_addr),
    .hit       (l2_hit),
    .hit_way   (l2_hit_way),
    .hit_data  (l2_hit_data),
    .vic_way   (l2_vic_way),
    .vic_dirty (l2_vdirty),
    .vic_addr  (l2_vic_addr),
    .vic_data  (l2_vic_data),
    .acc_en    (l2_acc_en),
    .acc_wr    (l2_acc_wr),
    .acc_way   (l2_acc_way),
    .acc_data  (l2_acc_data),
    .acc_dirty (l2_acc_dirty)
  );

  // first-level write port: write hits and read fills
  always_comb begin
    l1_wr_en    = 1'b0;
    l1_wr_addr  = r_addr;
    l1_wr_data  = mem_rdata;
    l1_wr_dirty = 1'b0;
    unique case (state)
      ST_IDLE: begin
        l1_wr_en    = req_valid && l1_hit && req_we;
        l1_wr_addr  = req_addr;
        l1_wr_data  = req_wdata;
        l1_wr_dirty = 1'b1;
      end
      ST_L2_LOOK: begin
        l1_wr_en   = l2_hit && !r_we;
        l1_wr_data = l2_hit_data;
      end
      ST_RD_MEM: l1_wr_en = mem_ack;
      default: ;
    endcase
  end

  // second-level access port: victim absorb, hits, fills
  always_comb begin
    l2_acc_en    = 1'b0;
    l2_acc_wr    = 1'b0;
    l2_acc_way   = l2_hit_way;
    l2_acc_data  = r_wdata;
    l2_acc_dirty = 1'b1;
    unique case (state)
      ST_VIC_L2: begin
        l2_acc_en   = l2_hit;
        l2_acc_wr   = 1'b1;
        l2_acc_data = v_data;
      end
      ST_L2_LOOK: begin
        l2_acc_en = l2_hit;
        l2_acc_wr = r_we;
      end
      ST_RD_MEM: begin
        l2_acc_en    = mem_ack;
        l2_acc_wr    = 1'b1;
        l2_acc_way   = e_way;
        l2_acc_data  = mem_rdata;
        l2_acc_dirty = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      r_we       <= 1'b0;
      r_addr     <= '0;
      r_wdata    <= '0;
      v_addr     <= '0;
      v_data     <= '0;
      e_way      <= '0;
    end else begin
      resp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (l1_hit) begin
              resp_valid <= 1'b1;
              resp_rdata <= req_we ? req_wdata : l1_rdata;
            end else begin
              r_we    <= req_we;
              r_addr  <= req_addr;
              r_wdata <= req_wdata;
              v_addr  <= l1_vaddr;
              v_data  <= l1_rdata;
              state   <= (!req_we && l1_vdirty) ? ST_VIC_L2 : ST_L2_LOOK;
            end
          end
        end
        ST_VIC_L2: begin
          if (l2_hit) begin
            state <= ST_L2_LOOK;
          end else begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= v_addr;
            mem_wdata <= v_data;
            state     <= ST_VIC_MEM;
          end
        end
        ST_VIC_MEM: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            state   <= ST_L2_LOOK;
          end
        end
        ST_L2_LOOK: begin
          if (l2_hit) begin
            resp_valid <= 1'b1;
            resp_rdata <= r_we ? r_wdata : l2_hit_data;
            state      <= ST_IDLE;
          end else if (r_we) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= r_addr;
            mem_wdata <= r_wdata;
            state     <= ST_WR_MEM;
          end else begin
            e_way <= l2_vic_way;
            if (l2_vdirty) begin
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= l2_vic_addr;
              mem_wdata <= l2_vic_data;
              state     <= ST_EVICT_MEM;
            end else begin
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= r_addr;
              state    <= ST_RD_MEM;
            end
          end
        end
        ST_EVICT_MEM: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            state   <= ST_RD_ISSUE;
          end
        end
        ST_RD_ISSUE: begin
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= r_addr;
          state    <= ST_RD_MEM;
        end
        ST_RD_MEM: begin
          if (mem_ack) begin
            mem_req    <= 1'b0;
            resp_valid <= 1'b1;
            resp_rdata <= mem_rdata;
            state      <= ST_IDLE;
          end
        end
        ST_WR_MEM: begin
          if (mem_ack) begin
            mem_req    <= 1'b0;
            resp_valid <= 1'b1;
            resp_rdata <= r_wdata;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/twolvl_cache_chk.sv
`timescale 1ns/1ps
module twolvl_cache_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack
);

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_ready && !resp_valid && !mem_req));

  // R2
  accept_hit_or_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (resp_valid || !req_ready));

  // R11
  busy_during_mem_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R11
  mem_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> !mem_req);

  // R12
  resp_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> req_ready);

endmodule

bind twolvl_cache twolvl_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_ack    (mem_ack)
);

// File: tb/twolvl_cache_bench.sv
`timescale 1ns/1ps
module twolvl_cache_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready, req_we;
  logic [15:0] req_addr;
  logic [31:0] req_wdata;
  logic        resp_valid;
  logic [31:0] resp_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  twolvl_cache u_twolvl_cache (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_we     (req_we),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .resp_valid (resp_valid),
    .resp_rdata (resp_rdata),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int rd_ops = 0;
  int wr_ops = 0;

  logic [31:0] exp_q [$];
  logic [31:0] ref_mem  [int];
  logic [31:0] back_mem [int];
  logic        op_we_log   [$];
  logic [15:0] op_addr_log [$];
  logic [31:0] op_data_log [$];

  function automatic logic [31:0] init_word(input logic [15:0] a);
    return {a ^ 16'h5A5A, a};
  endfunction

  function automatic logic [31:0] ref_rd(input logic [15:0] a);
    if (ref_mem.exists(int'(a))) return ref_mem[int'(a)];
    return init_word(a);
  endfunction

  function automatic logic [31:0] back_rd(input logic [15:0] a);
    if (back_mem.exists(int'(a))) return back_mem[int'(a)];
    return init_word(a);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model with 1..4 cycle latency, one ack per access
  initial begin
    int lat_sel = 0;
    mem_ack   = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (!rst && mem_req) begin
        logic [15:0] a;
        logic        we;
        logic [31:0] d;
        bit          held;
        a    = mem_addr;
        we   = mem_we;
        d    = mem_wdata;
        held = 1'b1;
        for (int i = 0; i < 1 + (lat_sel % 4); i++) begin
          @(negedge clk);
          if (!mem_req || mem_addr != a || mem_we != we) held = 1'b0;
        end
        lat_sel++;
        check(held, "R11 memory request held until ack", {16'h0, mem_addr}, {16'h0, a});
        if (we) begin
          back_mem[int'(a)] = d;
          wr_ops++;
        end else begin
          mem_rdata = back_rd(a);
          rd_ops++;
        end
        op_we_log.push_back(we);
        op_addr_log.push_back(a);
        op_data_log.push_back(d);
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && resp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R12 response without request", resp_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        check(resp_rdata == e, "R4 R12 response word", resp_rdata, e);
      end
    end
  end

  // lat_mode: 1 = single cycle, 2 = longer, 0 = any; counts < 0 are not checked
  task automatic do_req(input bit we, input logic [15:0] a, input logic [31:0] d,
                        input int exp_rd, input int exp_wr, input int lat_mode,
                        input string tag);
    int  rd0, wr0, lat;
    bit  busy_ok;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rd0 = rd_ops;
    wr0 = wr_ops;
    if (we) begin
      ref_mem[int'(a)] = d;
      exp_q.push_back(d);
    end else begin
      exp_q.push_back(ref_rd(a));
    end
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    lat       = 1;
    busy_ok   = 1'b1;
    while (!resp_valid && lat < 1000) begin
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk);
      lat++;
    end
    if (lat_mode == 1)
      check(lat == 1, {tag, " single-cycle latency"}, lat, 1);
    if (lat_mode == 2) begin
      check(lat > 1, {tag, " multi-cycle latency"}, lat, 2);
      check(busy_ok, "R11 ready low while sequencing", {31'h0, busy_ok}, 1);
    end
    if (exp_rd >= 0)
      check(rd_ops - rd0 == exp_rd, {tag, " memory reads"}, rd_ops - rd0, exp_rd);
    if (exp_wr >= 0)
      check(wr_ops - wr0 == exp_wr, {tag, " memory writes"}, wr_ops - wr0, exp_wr);
  endtask

  task automatic clear_log();
    op_we_log.delete();
    op_addr_log.delete();
    op_data_log.delete();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  localparam logic [31:0] D1 = 32'h1111_0010;
  localparam logic [31:0] D2 = 32'h2222_0050;
  localparam logic [31:0] D3 = 32'h3333_0123;

  initial begin
    logic [31:0] seed;
    rst       = 1'b1;
    req_valid = 1'b0;
    req_we    = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 idle outputs after reset
    check(req_ready && !resp_valid && !mem_req, "R1 idle after reset",
          {29'h0, req_ready, resp_valid, mem_req}, 32'h4);

    // R1 R4 cold read goes to memory, then hits
    do_req(1'b0, 16'h0010, '0, 1, 0, 2, "R1 R4 cold read");
    do_req(1'b0, 16'h0010, '0, 0, 0, 1, "R2 R4 repeat read hit");
    // R5 write hit stays in the first level
    do_req(1'b1, 16'h0010, D1, 0, 0, 1, "R5 write hit");
    do_req(1'b0, 16'h0010, '0, 0, 0, 1, "R5 read after write hit");
    @(negedge clk);
    check(!resp_valid, "R12 single-cycle response pulse", {31'h0, resp_valid}, 0);
    // R8 dirty first-level victim absorbed by the second level
    do_req(1'b0, 16'h0020, '0, 1, 0, 2, "R8 dirty victim to second level");
    do_req(1'b0, 16'h0010, '0, 0, 0, 2, "R3 R8 second-level hit");
    // R9 fill the rest of set 0
    do_req(1'b0, 16'h0030, '0, 1, 0, 2, "R9 fill way 2");
    do_req(1'b0, 16'h0040, '0, 1, 0, 2, "R9 fill way 3");
    do_req(1'b0, 16'h0020, '0, 0, 0, 2, "R3 R9 touch way 1");
    // R9 R10 oldest way is dirty 0x0010: written out before the read
    clear_log();
    do_req(1'b0, 16'h0050, '0, 1, 1, 2, "R9 R10 dirty age eviction");
    check(op_we_log.size() == 2 && op_we_log[0] == 1'b1 && op_we_log[1] == 1'b0,
          "R10 write-back before read", op_we_log.size(), 2);
    if (op_we_log.size() == 2) begin
      check(op_addr_log[0] == 16'h0010 && op_data_log[0] == D1, "R10 evicted line contents",
            op_data_log[0], D1);
      check(op_addr_log[1] == 16'h0050, "R4 memory read address", {16'h0, op_addr_log[1]},
            32'h0050);
    end
    do_req(1'b0, 16'h0010, '0, 1, 0, 2, "R10 evicted data refetched");
    do_req(1'b0, 16'h0060, '0, 1, 0, 2, "R9 evicts 0x0040");
    do_req(1'b0, 16'h0040, '0, 1, 0, 2, "R9 evicted line misses");
    // R6 write miss first level, hit second level
    do_req(1'b1, 16'h0050, D2, 0, 0, 2, "R6 write to second level");
    do_req(1'b0, 16'h0050, '0, 0, 0, 2, "R6 no first-level allocation");
    // R7 write miss in both levels
    clear_log();
    do_req(1'b1, 16'h0123, D3, 0, 1, 2, "R7 write-through on double miss");
    if (op_we_log.size() == 1)
      check(op_addr_log[0] == 16'h0123 && op_data_log[0] == D3, "R7 memory write fields",
            op_data_log[0], D3);
    else
      check(1'b0, "R7 memory write count", op_we_log.size(), 1);
    do_req(1'b0, 16'h0123, '0, 1, 0, 2, "R7 no allocation on write miss");
    do_req(1'b0, 16'h0123, '0, 0, 0, 1, "R2 hit after fill");

    // mixed traffic over four sets, eight tags each
    seed = 32'h1357_9BDF;
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      bit          w;
      seed = seed * 32'd1664525 + 32'd1013904223;
      a = {9'h0, seed[30:28], 2'b00, seed[21:20]};
      w = seed[15];
      do_req(w, a, seed ^ 32'hA5A5_0000, -1, -1, 0, "R4 R9 mixed traffic");
    end
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R12 every request answered", exp_q.size(), 0);
    finish_run();
  end

endmodule